// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This block carries out the four partial-word instructions that let software move a 32-bit value to or from a byte address that is not word aligned. Memory is little-endian. Two of the instructions are loads and two are stores: load-upper-part, load-lower-part, store-upper-part and store-lower-part. A request gives the operation, the byte address, the current value of the register involved and, for loads, the index of the destination register. The unit reads the word that contains the address through a simple request/response memory port. The two low address bits then select how the memory word and the register value are combined.

For the two load operations, the merged value is returned with a one-cycle `done` pulse. A register-write enable comes with it. For the two store operations, the merged word is written back to the same aligned address. This makes each store a read-modify-write, and the memory needs no byte enables. Only one operation is in flight at a time. A request is taken only while the unit is idle. The memory response may arrive any number of cycles after the read request.

Top module: `unaligned_merge_unit`

## Requirements
- R1: Every memory access, read or write, presents the request address with its two low bits forced to zero.
- R2: Load-upper (op code 2'b00), with byte offset k = addr[1:0] and s = 24, 16, 8, 0 for k = 0..3, returns (reg AND keep) OR (mem << s). Here keep is 0x00FFFFFF, 0x0000FFFF, 0x000000FF, 0x00000000 for k = 0..3.
- R3: Load-lower (op code 2'b01), with s = 8·k, returns (reg AND keep) OR (mem >> s). Here keep is 0x00000000, 0xFF000000, 0xFFFF0000, 0xFFFFFF00 for k = 0..3.
- R4: Store-upper (op code 2'b10), with s = 24, 16, 8, 0 for k = 0..3, writes (reg >> s) OR (mem AND keep). Here keep is 0xFFFFFF00, 0xFFFF0000, 0xFF000000, 0x00000000 for k = 0..3.
- R5: Store-lower (op code 2'b11), with s = 8·k, writes (reg << s) OR (mem AND keep). Here keep is 0x00000000, 0x000000FF, 0x0000FFFF, 0x00FFFFFF for k = 0..3.
- R6: A store makes exactly one read and then exactly one write, to the same aligned address, and the write comes before `done`. A load makes exactly one read and no write.
- R7: `res_wen` is high only together with `done` for a load whose destination index is nonzero. For a load to register 0 and for every store it stays low.
- R8: `done` is a single-cycle pulse. `req_ready` is high only while idle. A request presented while the unit is busy is ignored and starts no memory access.
- R9: The merge uses the memory response only once `mem_rvalid` is high. With any response latency, `done` never comes before the response.
- R10: After reset the unit is idle: `req_ready` is high, and `mem_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 2 | Operation: 00 load-upper, 01 load-lower, 10 store-upper, 11 store-lower |
| req_addr | input | ADDR_W | Byte address |
| req_reg | input | DATA_W | Current register value |
| req_rd | input | IDX_W | Destination register index (loads) |
| mem_req | output | 1 | Memory access strobe, one cycle per access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Aligned word address |
| mem_wdata | output | DATA_W | Merged word for a store |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DATA_W | Read response word |
| done | output | 1 | Operation complete, one cycle |
| res_data | output | DATA_W | Merged value (load result, or word stored) |
| res_wen | output | 1 | Register file write enable |
| res_rd | output | IDX_W | Register index to write |

## Verification
All four operations are run at all four byte offsets against memory words and register values whose bytes are all different. A byte that comes from the wrong source, or from the wrong lane, therefore shows up in the result, and an offset that is mapped to the wrong mask or shift is caught. Stores are run back to back on the same word. A second store then merges into data left by the first, which shows whether the read-modify-write really wrote what it claimed. Response latencies of zero to six cycles separate a merge that waits for the memory from one that takes stale data. A load to register 0 and a request held high while the unit is busy test the write-enable suppression and the request filtering.

// File: rtl/umu_pkg.sv
package umu_pkg;

   typedef enum logic [1:0] {
      OP_LD_UP = 2'b00,
      OP_LD_LO = 2'b01,
      OP_ST_UP = 2'b10,
      OP_ST_LO = 2'b11
   } umu_op_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_MERGE = 3'd2,
      ST_WRITE = 3'd3,
      ST_DONE  = 3'd4
   } umu_state_e;

   function automatic logic op_is_store(umu_op_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/umu_merge.sv
module umu_merge
   import umu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int STYLE  = 0,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  umu_op_e            op,
   input  logic [OFF_W-1:0]   off,
   input  logic [DATA_W-1:0]  reg_val,
   input  logic [DATA_W-1:0]  mem_val,
   output logic [DATA_W-1:0]  merged
);

   if (STYLE == 0) begin : g_shift_mask
      logic [DATA_W-1:0] ones;
      int                up_sh;
      int                lo_sh;
      assign ones = '1;
      always_comb begin
         up_sh = (LANES - 1 - int'(off)) * 8;
         lo_sh = int'(off) * 8;
         unique case (op)
            OP_LD_UP: merged = (reg_val & ~(ones << up_sh)) | (mem_val << up_sh);
            OP_LD_LO: merged = (reg_val & ~(ones >> lo_sh)) | (mem_val >> lo_sh);
            OP_ST_UP: merged = (reg_val >> up_sh) | (mem_val & ~(ones >> up_sh));
            default:  merged = (reg_val << lo_sh) | (mem_val & ~(ones << lo_sh));
         endcase
      end
   end else begin : g_byte_mux
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         int k;
         int src;
         always_comb begin
            k   = int'(off);
            src = j;
            merged[j*8 +: 8] = reg_val[j*8 +: 8];
            unique case (op)
               OP_LD_UP: begin
                  src = j - (LANES - 1 - k);
                  if (src >= 0) merged[j*8 +: 8] = mem_val[src*8 +: 8];
               end
               OP_LD_LO: begin
                  src = j + k;
                  if (src < LANES) merged[j*8 +: 8] = mem_val[src*8 +: 8];
               end
               OP_ST_UP: begin
                  src = j + (LANES - 1 - k);
                  if (j <= k) merged[j*8 +: 8] = reg_val[src*8 +: 8];
                  else        merged[j*8 +: 8] = mem_val[j*8 +: 8];
               end
               default: begin
                  src = j - k;
                  if (src >= 0) merged[j*8 +: 8] = reg_val[src*8 +: 8];
                  else          merged[j*8 +: 8] = mem_val[j*8 +: 8];
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/umu_ctrl.sv
module umu_ctrl
   import umu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       is_store,
   input  logic       rsp_valid,
   output umu_state_e state,
   output logic       idle,
   output logic       accept,
   output logic       capture,
   output logic       mem_req,
   output logic       mem_we,
   output logic       done
);

   umu_state_e nxt;

   assign idle    = (state == ST_IDLE);
   assign accept  = idle && req_valid;
   assign capture = (state == ST_MERGE) && rsp_valid;
   assign mem_req = (state == ST_READ) || (state == ST_WRITE);
   assign mem_we  = (state == ST_WRITE);
   assign done    = (state == ST_DONE);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (req_valid) nxt = ST_READ;
         ST_READ:  nxt = ST_MERGE;
         ST_MERGE: if (rsp_valid) nxt = is_store ? ST_WRITE : ST_DONE;
         ST_WRITE: nxt = ST_DONE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R8: completion lasts exactly one cycle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: no memory traffic while the unit reports itself idle
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !mem_req);

endmodule

// File: rtl/unaligned_merge_unit.sv
module unaligned_merge_unit
   import umu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = 5,
   parameter int MERGE_STYLE = 0,
   localparam int LANES      = DATA_W / 8,
   localparam int OFF_W      = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_reg,
   input  logic [IDX_W-1:0]  req_rd,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic [DATA_W-1:0] res_data,
   output logic              res_wen,
   output logic [IDX_W-1:0]  res_rd
);

   if (DATA_W % 8 != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
      $error("unaligned_merge_unit: DATA_W must be a power-of-two count of bytes, at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("unaligned_merge_unit: ADDR_W too small");
   end
   if (MERGE_STYLE != 0 && MERGE_STYLE != 1) begin : g_bad_style
      $error("unaligned_merge_unit: MERGE_STYLE must be 0 or 1");
   end

   umu_op_e                  op_q;
   logic [ADDR_W-1:OFF_W]    base_q;
   logic [OFF_W-1:0]         off_q;
   logic [DATA_W-1:0]        reg_q;
   logic [IDX_W-1:0]         rd_q;
   logic [DATA_W-1:0]        res_q;
   logic [DATA_W-1:0]        merged;
   umu_state_e               state;
   logic                     idle, accept, capture;

   umu_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .is_store  (op_is_store(op_q)),
      .rsp_valid (mem_rvalid),
      .state     (state),
      .idle      (idle),
      .accept    (accept),
      .capture   (capture),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .done      (done)
   );

   umu_merge #(
      .DATA_W (DATA_W),
      .STYLE  (MERGE_STYLE)
   ) u_merge (
      .op      (op_q),
      .off     (off_q),
      .reg_val (reg_q),
      .mem_val (mem_rdata),
      .merged  (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_LD_UP;
         base_q <= '0;
         off_q  <= '0;
         reg_q  <= '0;
         rd_q   <= '0;
      end else if (accept) begin
         op_q   <= umu_op_e'(req_op);
         base_q <= req_addr[ADDR_W-1:OFF_W];
         off_q  <= req_addr[OFF_W-1:0];
         reg_q  <= req_reg;
         rd_q   <= req_rd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       res_q <= '0;
      else if (capture) res_q <= merged;
   end

   assign req_ready = idle;
   assign mem_addr  = {base_q, {OFF_W{1'b0}}};
   assign mem_wdata = res_q;
   assign res_data  = res_q;
   assign res_rd    = rd_q;
   assign res_wen   = done && !op_is_store(op_q) && (rd_q != '0);

   // checker state: a response has been seen for the operation in flight
   logic rsp_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rsp_seen <= 1'b0;
      else if (accept)                  rsp_seen <= 1'b0;
      else if (mem_rvalid && !idle)     rsp_seen <= 1'b1;
   end

   // R1: memory addresses are word aligned
   a_r1_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFF_W-1:0] == '0));

   // R6: a write strobe is followed directly by completion
   a_r6_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> done);

   // R7: register zero is never written
   a_r7_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
      res_wen |-> (res_rd != '0) && done);

   // R9: completion only after the memory has answered
   a_r9_rsp_before_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> rsp_seen);

endmodule

// File: tb/sim_unaligned_merge_unit.sv
module sim_unaligned_merge_unit;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 32;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_reg = '0;
   logic [IW-1:0] req_rd = '0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_rvalid = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          done;
   logic [DW-1:0] res_data;
   logic          res_wen;
   logic [IW-1:0] res_rd;

   always #(CLK_PERIOD/2) clk = ~clk;

   unaligned_merge_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_reg(req_reg), .req_rd(req_rd),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
      .res_data(res_data), .res_wen(res_wen), .res_rd(res_rd)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [31:0] mem [16];
   int          lat = 0;
   bit          pend = 0;
   int          cnt = 0;
   int          pidx = 0;
   int          rd_count = 0, wr_count = 0;
   logic [31:0] rd_addr_seen = '0, wr_addr_seen = '0, wr_data_seen = '0;
   bit          rsp_given = 0;
   bit          wr_before_rd = 0;

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (req_valid && req_ready && rst_n) begin
         rd_count = 0; wr_count = 0; rsp_given = 0; wr_before_rd = 0;
      end
      if (pend) begin
         if (cnt == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[pidx];
            pend = 0;
            rsp_given = 1;
         end else cnt--;
      end
      if (mem_req && !mem_we) begin
         rd_count++; rd_addr_seen = mem_addr;
         pend = 1; cnt = lat; pidx = int'(mem_addr[5:2]);
      end
      if (mem_req && mem_we) begin
         if (rd_count == 0) wr_before_rd = 1;
         wr_count++; wr_addr_seen = mem_addr; wr_data_seen = mem_wdata;
         mem[mem_addr[5:2]] = mem_wdata;
      end
   end

   // ---------------- expected model ----------------
   function automatic logic [31:0] expect_val(logic [1:0] op, logic [1:0] k,
                                               logic [31:0] r, logic [31:0] m);
      logic [31:0] keep;
      int s;
      case (op)
         2'b00: begin
            case (k) 0: keep = 32'h00FFFFFF; 1: keep = 32'h0000FFFF;
                     2: keep = 32'h000000FF; default: keep = 32'h0; endcase
            s = 24 - 8*int'(k);
            return (r & keep) | (m << s);
         end
         2'b01: begin
            case (k) 0: keep = 32'h0; 1: keep = 32'hFF000000;
                     2: keep = 32'hFFFF0000; default: keep = 32'hFFFFFF00; endcase
            s = 8*int'(k);
            return (r & keep) | (m >> s);
         end
         2'b10: begin
            case (k) 0: keep = 32'hFFFFFF00; 1: keep = 32'hFFFF0000;
                     2: keep = 32'hFF000000; default: keep = 32'h0; endcase
            s = 24 - 8*int'(k);
            return (r >> s) | (m & keep);
         end
         default: begin
            case (k) 0: keep = 32'h0; 1: keep = 32'h000000FF;
                     2: keep = 32'h0000FFFF; default: keep = 32'h00FFFFFF; endcase
            s = 8*int'(k);
            return (r << s) | (m & keep);
         end
      endcase
   endfunction

   typedef struct {
      bit          store;
      logic [31:0] data;
      bit          wen;
      logic [4:0]  rd;
      logic [31:0] aligned;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   bit   prev_done = 0;
   int   unexpected = 0;

   // ---------------- monitor ----------------
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done) begin
            check(!prev_done, "R8 done width", 32'(prev_done), 0);
            if (exp_q.size() == 0) begin
               unexpected++;
               check(0, "R8 unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(res_wen == e.wen, "R7 res_wen", 32'(res_wen), 32'(e.wen));
               if (e.wen) check(res_rd == e.rd, "R7 res_rd", 32'(res_rd), 32'(e.rd));
               check(rd_addr_seen == e.aligned, "R1 read address", rd_addr_seen, e.aligned);
               check(rd_count == 1, "R6 read count", rd_count, 1);
               check(rsp_given, "R9 done before response", 32'(rsp_given), 1);
               if (e.store) begin
                  check(wr_count == 1 && !wr_before_rd, "R6 store write count/order",
                        wr_count, 1);
                  check(wr_addr_seen == e.aligned, "R1 write address", wr_addr_seen, e.aligned);
                  check(wr_data_seen == e.data, e.tag, wr_data_seen, e.data);
               end else begin
                  check(wr_count == 0, "R6 load wrote memory", wr_count, 0);
                  check(res_data == e.data, e.tag, res_data, e.data);
               end
            end
         end
         prev_done = done;
      end
   end

   // ---------------- driver ----------------
   task automatic issue(logic [1:0] op, logic [31:0] addr, logic [31:0] rv,
                        logic [4:0] rd, int latency);
      exp_t e;
      while (!req_ready) @(negedge clk);
      e.store   = op[1];
      e.data    = expect_val(op, addr[1:0], rv, mem[addr[5:2]]);
      e.wen     = !op[1] && (rd != 0);
      e.rd      = rd;
      e.aligned = {addr[31:2], 2'b00};
      case (op)
         2'b00: e.tag = "R2 load-upper";
         2'b01: e.tag = "R3 load-lower";
         2'b10: e.tag = "R4 store-upper";
         default: e.tag = "R5 store-lower";
      endcase
      exp_q.push_back(e);
      lat = latency;
      req_op = op; req_addr = addr; req_reg = rv; req_rd = rd;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 16; i++)
         mem[i] = 32'hA0B1C2D3 + i * 32'h01020304;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(req_ready == 1'b1, "R10 ready in reset", 32'(req_ready), 1);
      check(mem_req == 1'b0, "R10 mem_req in reset", 32'(mem_req), 0);
      check(done == 1'b0, "R10 done in reset", 32'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 1);

      // R2..R5 all operations, all offsets, varying latency (R9)
      for (int op = 0; op < 4; op++) begin
         for (int k = 0; k < 4; k++) begin
            issue(2'(op), 32'h0000_0040 + 32'(4*(op*4 + k)) + 32'(k) - 32'h40 + 32'h10 * 0 + 32'(k*0),
                  32'h1A2B3C4D + 32'(op*16 + k), 5'(3 + k), (op + k) % 7);
            wait_idle();
         end
      end

      // R6: back-to-back stores into the same word
      issue(2'b10, 32'h0000_0025, 32'hDEADBEEF, 5'd1, 2);
      wait_idle();
      issue(2'b11, 32'h0000_0026, 32'h01234567, 5'd1, 0);
      wait_idle();
      issue(2'b01, 32'h0000_0024, 32'hFFFFFFFF, 5'd9, 1);
      wait_idle();

      // R7: load to register zero
      issue(2'b00, 32'h0000_0031, 32'h55AA55AA, 5'd0, 3);
      wait_idle();
      issue(2'b01, 32'h0000_0033, 32'h55AA55AA, 5'd0, 0);
      wait_idle();

      // R9: long response latency
      issue(2'b00, 32'h0000_0012, 32'h0F0F0F0F, 5'd31, 6);
      wait_idle();

      // R8: request held while busy is ignored
      issue(2'b11, 32'h0000_0009, 32'hCAFEF00D, 5'd2, 4);
      req_op = 2'b00; req_addr = 32'h0000_0001; req_reg = 32'h0; req_rd = 5'd7;
      req_valid = 1'b1;
      for (int c = 0; c < 3; c++) begin
         check(req_ready == 1'b0, "R8 ready while busy", 32'(req_ready), 0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      wait_idle();
      repeat (12) @(negedge clk);
      check(unexpected == 0 && exp_q.size() == 0, "R8 busy request ignored", unexpected, 0);
      check(req_ready == 1'b1, "R8 idle again", 32'(req_ready), 1);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule